// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two component predictors look at the branch in parallel. The first is a per-branch path: instruction-address bits select a 10-bit history of that branch's own past outcomes, and that history selects a 3-bit counter. The second is a global path: a 12-bit shift register of recent predicted outcomes selects a 2-bit counter. A third table of 2-bit counters, also indexed by the global history, chooses which of the two components gives the final answer.

The fetch stage presents the index bits of the branch PC and reads the answer in the same cycle. The answer carries the final direction, both component guesses and the global history that was used. When the fetch stage accepts the prediction, the global history shifts in the predicted direction on the next clock edge. The pipeline keeps the returned values with the branch. At retirement it sends them back with the real outcome, and every table is trained from those values. After a misprediction, the recovery port rebuilds the global history from the saved snapshot plus the corrected outcome.

Top module: `tourney_bp`

## Requirements
- R1: After reset, every 3-bit counter holds 3, every 2-bit counter holds 1, and all histories hold zero. Every prediction output is therefore 0 and `pred_ghist_o` reads 0.
- R2: A retire shifts `ret_taken_i` into bit 0 of the local-history entry selected by `ret_pc_i`, and the older bits move up by one. The PC inputs carry instruction-address bits 11:2.
- R3: `pred_local_o` is bit 2 of the 3-bit counter selected by the current local history of the entry at `pred_pc_i`. A retire moves the counter selected by the retiring entry's pre-update history one step toward the outcome.
- R4: `pred_global_o` is bit 1 of the 2-bit counter selected by the current global history. A retire moves the counter at `ret_ghist_i` one step toward the outcome.
- R5: The chooser counter at the current global history picks the final prediction. When its bit 1 is 1, `pred_taken_o` equals the global guess; otherwise it equals the local guess.
- R6: When `ret_local_i` differs from `ret_global_i`, the chooser counter at `ret_ghist_i` steps up if the global guess matched the outcome and steps down if it did not.
- R7: When `ret_local_i` equals `ret_global_i`, the chooser counter is left unchanged.
- R8: With `pred_valid_i` high and no recovery, the global history becomes `{history[10:0], pred_taken_o}` on the next edge.
- R9: With neither `pred_valid_i` nor `rec_valid_i` high, the global history keeps its value.
- R10: With `rec_valid_i` high, the global history becomes `{rec_hist_i, rec_taken_i}` on the next edge. This takes priority over a prediction in the same cycle.
- R11: Counters saturate: 3-bit counters stay within 0..7 and 2-bit counters stay within 0..3, with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_valid_i | input | 1 | Prediction accepted; shift it into the global history |
| pred_pc_i | input | 10 | PC bits 11:2 of the branch being predicted |
| pred_taken_o | output | 1 | Final predicted direction |
| pred_local_o | output | 1 | Local component guess |
| pred_global_o | output | 1 | Global component guess |
| pred_ghist_o | output | 12 | Global history used for this prediction |
| ret_valid_i | input | 1 | A branch retires this cycle |
| ret_pc_i | input | 10 | PC bits 11:2 of the retiring branch |
| ret_taken_i | input | 1 | Real outcome of the retiring branch |
| ret_local_i | input | 1 | Local guess recorded at prediction |
| ret_global_i | input | 1 | Global guess recorded at prediction |
| ret_ghist_i | input | 12 | Global history recorded at prediction |
| rec_valid_i | input | 1 | Restore the global history |
| rec_hist_i | input | 11 | Low 11 bits of the recorded global history |
| rec_taken_i | input | 1 | Corrected outcome to shift in on recovery |

## Verification
The assertions assume that the caller drives `pred_valid_i`, `rec_valid_i` and their data low or stable across reset. They also assume that the values returned on the retire port are the ones the block produced, so that the component guesses and the snapshot are consistent. The directed stimulus builds each scenario from a fresh reset. It retires only branches whose recorded guesses and snapshots it chose on purpose. It holds every strobe low while reset is active and for several cycles after release. Training values are chosen so that each table entry under test is reached through one known index alone.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  typedef enum logic {
    PICK_LOCAL  = 1'b0,
    PICK_GLOBAL = 1'b1
  } pick_e;

  localparam int unsigned DEF_LIDX_W  = 10;
  localparam int unsigned DEF_LHIST_W = 10;
  localparam int unsigned DEF_LCTR_W  = 3;
  localparam int unsigned DEF_GH_W    = 12;
  localparam int unsigned DEF_GCTR_W  = 2;
  localparam int unsigned DEF_CH_W    = 2;
endpackage

// File: rtl/tbp_rst_sync.sv
module tbp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tbp_satcnt.sv
module tbp_satcnt #(
  parameter int unsigned W = 2
) (
  input  logic [W-1:0] cnt_i,
  input  logic         up_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] TOP  = {W{1'b1}};
  localparam logic [W-1:0] BOT  = {W{1'b0}};
  localparam logic [W-1:0] STEP = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    if (up_i) cnt_o = (cnt_i == TOP) ? cnt_i : cnt_i + STEP;
    else      cnt_o = (cnt_i == BOT) ? cnt_i : cnt_i - STEP;
  end
endmodule

// File: rtl/tbp_local.sv
module tbp_local #(
  parameter int unsigned LIDX_W  = 10,
  parameter int unsigned LHIST_W = 10,
  parameter int unsigned LCTR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LIDX_W-1:0] rd_idx_i,
  output logic              rd_pred_o,
  input  logic              wr_en_i,
  input  logic [LIDX_W-1:0] wr_idx_i,
  input  logic              wr_taken_i
);
  localparam int unsigned LHT_N  = 1 << LIDX_W;
  localparam int unsigned LCTR_N = 1 << LHIST_W;
  localparam logic [LCTR_W-1:0] WEAK_NT = {1'b0, {(LCTR_W-1){1'b1}}};

  logic [LHIST_W-1:0] lht_q  [LHT_N];
  logic [LCTR_W-1:0]  lctr_q [LCTR_N];

  logic [LHIST_W-1:0] rd_hist;
  logic [LCTR_W-1:0]  rd_ctr;
  logic [LHIST_W-1:0] wr_hist;
  logic [LHIST_W-1:0] hist_nxt;
  logic [LCTR_W-1:0]  ctr_cur;
  logic [LCTR_W-1:0]  ctr_nxt;

  always_comb begin
    rd_hist   = lht_q[rd_idx_i];
    rd_ctr    = lctr_q[rd_hist];
    rd_pred_o = rd_ctr[LCTR_W-1];
  end

  always_comb begin
    wr_hist  = lht_q[wr_idx_i];
    hist_nxt = {wr_hist[LHIST_W-2:0], wr_taken_i};
    ctr_cur  = lctr_q[wr_hist];
  end

  tbp_satcnt #(.W(LCTR_W)) i_lctr_step (
    .cnt_i (ctr_cur),
    .up_i  (wr_taken_i),
    .cnt_o (ctr_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LHT_N; i++) lht_q[i] <= '0;
    end else if (wr_en_i) begin
      lht_q[wr_idx_i] <= hist_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LCTR_N; i++) lctr_q[i] <= WEAK_NT;
    end else if (wr_en_i) begin
      lctr_q[wr_hist] <= ctr_nxt;
    end
  end
endmodule

// File: rtl/tbp_global.sv
module tbp_global #(
  parameter int unsigned GH_W   = 12,
  parameter int unsigned GCTR_W = 2,
  parameter int unsigned CH_W   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [GH_W-1:0] hist_o,
  output logic            rd_global_o,
  output logic            rd_use_global_o,
  input  logic            spec_en_i,
  input  logic            spec_taken_i,
  input  logic            rec_en_i,
  input  logic [GH_W-2:0] rec_hist_i,
  input  logic            rec_taken_i,
  input  logic            upd_en_i,
  input  logic [GH_W-1:0] upd_hist_i,
  input  logic            upd_taken_i,
  input  logic            upd_local_i,
  input  logic            upd_global_i
);
  localparam int unsigned G_N = 1 << GH_W;
  localparam logic [GCTR_W-1:0] G_WEAK_NT = {1'b0, {(GCTR_W-1){1'b1}}};
  localparam logic [CH_W-1:0]   C_WEAK_NT = {1'b0, {(CH_W-1){1'b1}}};

  logic [GH_W-1:0]   ghist_q;
  logic [GH_W-1:0]   ghist_d;
  logic              ghist_en;
  logic [GCTR_W-1:0] gctr_q [G_N];
  logic [CH_W-1:0]   chs_q  [G_N];

  logic [GCTR_W-1:0] rd_gctr;
  logic [CH_W-1:0]   rd_ch;
  logic [GCTR_W-1:0] g_cur;
  logic [GCTR_W-1:0] g_nxt;
  logic [CH_W-1:0]   c_cur;
  logic [CH_W-1:0]   c_nxt;
  logic              c_en;
  logic              c_up;

  // next-state of the speculative history; recovery has priority
  always_comb begin
    ghist_en = rec_en_i | spec_en_i;
    if (rec_en_i) ghist_d = {rec_hist_i, rec_taken_i};
    else          ghist_d = {ghist_q[GH_W-2:0], spec_taken_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ghist_q <= '0;
    else if (ghist_en) ghist_q <= ghist_d;
  end

  always_comb begin
    rd_gctr         = gctr_q[ghist_q];
    rd_ch           = chs_q[ghist_q];
    hist_o          = ghist_q;
    rd_global_o     = rd_gctr[GCTR_W-1];
    rd_use_global_o = rd_ch[CH_W-1];
  end

  always_comb begin
    g_cur = gctr_q[upd_hist_i];
    c_cur = chs_q[upd_hist_i];
    c_en  = upd_en_i && (upd_local_i != upd_global_i);
    c_up  = (upd_global_i == upd_taken_i);
  end

  tbp_satcnt #(.W(GCTR_W)) i_gctr_step (
    .cnt_i (g_cur),
    .up_i  (upd_taken_i),
    .cnt_o (g_nxt)
  );

  tbp_satcnt #(.W(CH_W)) i_chs_step (
    .cnt_i (c_cur),
    .up_i  (c_up),
    .cnt_o (c_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < G_N; i++) gctr_q[i] <= G_WEAK_NT;
    end else if (upd_en_i) begin
      gctr_q[upd_hist_i] <= g_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < G_N; i++) chs_q[i] <= C_WEAK_NT;
    end else if (c_en) begin
      chs_q[upd_hist_i] <= c_nxt;
    end
  end
endmodule

// File: rtl/tourney_bp.sv
module tourney_bp
  import tbp_pkg::*;
#(
  parameter int unsigned LIDX_W  = DEF_LIDX_W,
  parameter int unsigned LHIST_W = DEF_LHIST_W,
  parameter int unsigned LCTR_W  = DEF_LCTR_W,
  parameter int unsigned GH_W    = DEF_GH_W,
  parameter int unsigned GCTR_W  = DEF_GCTR_W,
  parameter int unsigned CH_W    = DEF_CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pred_valid_i,
  input  logic [LIDX_W-1:0] pred_pc_i,
  output logic              pred_taken_o,
  output logic              pred_local_o,
  output logic              pred_global_o,
  output logic [GH_W-1:0]   pred_ghist_o,
  input  logic              ret_valid_i,
  input  logic [LIDX_W-1:0] ret_pc_i,
  input  logic              ret_taken_i,
  input  logic              ret_local_i,
  input  logic              ret_global_i,
  input  logic [GH_W-1:0]   ret_ghist_i,
  input  logic              rec_valid_i,
  input  logic [GH_W-2:0]   rec_hist_i,
  input  logic              rec_taken_i
);
  logic  rst_sync_n;
  logic  loc_pred;
  logic  glb_pred;
  logic  use_glb;
  pick_e pick;

  tbp_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tbp_local #(
    .LIDX_W  (LIDX_W),
    .LHIST_W (LHIST_W),
    .LCTR_W  (LCTR_W)
  ) i_local (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rd_idx_i   (pred_pc_i),
    .rd_pred_o  (loc_pred),
    .wr_en_i    (ret_valid_i),
    .wr_idx_i   (ret_pc_i),
    .wr_taken_i (ret_taken_i)
  );

  tbp_global #(
    .GH_W   (GH_W),
    .GCTR_W (GCTR_W),
    .CH_W   (CH_W)
  ) i_global (
    .clk             (clk),
    .rst_n           (rst_sync_n),
    .hist_o          (pred_ghist_o),
    .rd_global_o     (glb_pred),
    .rd_use_global_o (use_glb),
    .spec_en_i       (pred_valid_i),
    .spec_taken_i    (pred_taken_o),
    .rec_en_i        (rec_valid_i),
    .rec_hist_i      (rec_hist_i),
    .rec_taken_i     (rec_taken_i),
    .upd_en_i        (ret_valid_i),
    .upd_hist_i      (ret_ghist_i),
    .upd_taken_i     (ret_taken_i),
    .upd_local_i     (ret_local_i),
    .upd_global_i    (ret_global_i)
  );

  always_comb begin
    pick          = use_glb ? PICK_GLOBAL : PICK_LOCAL;
    pred_local_o  = loc_pred;
    pred_global_o = glb_pred;
    pred_taken_o  = (pick == PICK_GLOBAL) ? glb_pred : loc_pred;
  end
endmodule

// File: rtl/tourney_bp_chk.sv
module tourney_bp_chk #(
  parameter int unsigned GH_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pred_valid_i,
  input logic            pred_taken_o,
  input logic            pred_local_o,
  input logic            pred_global_o,
  input logic [GH_W-1:0] pred_ghist_o,
  input logic            rec_valid_i,
  input logic [GH_W-2:0] rec_hist_i,
  input logic            rec_taken_i
);
  assert_spec_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid_i && !rec_valid_i) |=>
      (pred_ghist_o == {$past(pred_ghist_o[GH_W-2:0]), $past(pred_taken_o)}));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pred_valid_i && !rec_valid_i) |=> $stable(pred_ghist_o));

  assert_recover_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_i |=> (pred_ghist_o == {$past(rec_hist_i), $past(rec_taken_i)}));

  assert_agree_pick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_local_o == pred_global_o) |-> (pred_taken_o == pred_local_o));
endmodule

bind tourney_bp tourney_bp_chk #(.GH_W(GH_W)) i_tourney_bp_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .pred_valid_i  (pred_valid_i),
  .pred_taken_o  (pred_taken_o),
  .pred_local_o  (pred_local_o),
  .pred_global_o (pred_global_o),
  .pred_ghist_o  (pred_ghist_o),
  .rec_valid_i   (rec_valid_i),
  .rec_hist_i    (rec_hist_i),
  .rec_taken_i   (rec_taken_i)
);

// File: tb/test_tourney_bp.sv
module test_tourney_bp;
  logic        clk;
  logic        rst_n;
  logic        pred_valid_i;
  logic [9:0]  pred_pc_i;
  logic        pred_taken_o;
  logic        pred_local_o;
  logic        pred_global_o;
  logic [11:0] pred_ghist_o;
  logic        ret_valid_i;
  logic [9:0]  ret_pc_i;
  logic        ret_taken_i;
  logic        ret_local_i;
  logic        ret_global_i;
  logic [11:0] ret_ghist_i;
  logic        rec_valid_i;
  logic [10:0] rec_hist_i;
  logic        rec_taken_i;

  int n_cmp = 0;
  int n_bad = 0;

  tourney_bp i_tourney_bp (
    .clk           (clk),
    .rst_n         (rst_n),
    .pred_valid_i  (pred_valid_i),
    .pred_pc_i     (pred_pc_i),
    .pred_taken_o  (pred_taken_o),
    .pred_local_o  (pred_local_o),
    .pred_global_o (pred_global_o),
    .pred_ghist_o  (pred_ghist_o),
    .ret_valid_i   (ret_valid_i),
    .ret_pc_i      (ret_pc_i),
    .ret_taken_i   (ret_taken_i),
    .ret_local_i   (ret_local_i),
    .ret_global_i  (ret_global_i),
    .ret_ghist_i   (ret_ghist_i),
    .rec_valid_i   (rec_valid_i),
    .rec_hist_i    (rec_hist_i),
    .rec_taken_i   (rec_taken_i)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    pred_valid_i = 1'b0; pred_pc_i = '0;
    ret_valid_i = 1'b0; ret_pc_i = '0; ret_taken_i = 1'b0;
    ret_local_i = 1'b0; ret_global_i = 1'b0; ret_ghist_i = '0;
    rec_valid_i = 1'b0; rec_hist_i = '0; rec_taken_i = 1'b0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic retire(input logic [9:0] idx, input logic [11:0] gh,
                        input logic l, input logic g, input logic t);
    ret_valid_i = 1'b1; ret_pc_i = idx; ret_ghist_i = gh;
    ret_local_i = l; ret_global_i = g; ret_taken_i = t;
    @(negedge clk);
    ret_valid_i = 1'b0;
  endtask

  task automatic peek(input logic [9:0] idx);
    pred_pc_i = idx;
    #1;
  endtask

  task automatic step(input logic [9:0] idx);
    pred_pc_i = idx; pred_valid_i = 1'b1;
    @(negedge clk);
    pred_valid_i = 1'b0;
  endtask

  task automatic recover(input logic [10:0] h, input logic t);
    rec_valid_i = 1'b1; rec_hist_i = h; rec_taken_i = t;
    @(negedge clk);
    rec_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    peek(10'h040);
    check("R1", "taken", int'(pred_taken_o), 0);
    check("R1", "local", int'(pred_local_o), 0);
    check("R1", "global", int'(pred_global_o), 0);
    check("R1", "ghist", int'(pred_ghist_o), 0);
  endtask

  task automatic t_local();
    do_reset();
    retire(10'h040, 12'h000, 1'b0, 1'b0, 1'b1);
    peek(10'h041);
    check("R3", "local ctr[0] 3->4", int'(pred_local_o), 1);
    peek(10'h040);
    check("R2", "local hist shifted to 1", int'(pred_local_o), 0);
    retire(10'h041, 12'h009, 1'b0, 1'b0, 1'b0);
    peek(10'h042);
    check("R3", "local ctr[0] back to 3", int'(pred_local_o), 0);
  endtask

  task automatic t_global();
    do_reset();
    retire(10'h010, 12'h5A5, 1'b0, 1'b0, 1'b1);
    peek(10'h011);
    check("R4", "global at hist 0 untouched", int'(pred_global_o), 0);
    recover(11'h2D2, 1'b1);
    peek(10'h011);
    check("R10", "recovered ghist", int'(pred_ghist_o), 'h5A5);
    check("R4", "global at hist 5A5", int'(pred_global_o), 1);
  endtask

  task automatic t_choose();
    do_reset();
    retire(10'h020, 12'h005, 1'b0, 1'b1, 1'b1);
    recover(11'h002, 1'b1);
    peek(10'h020);
    check("R5", "local guess", int'(pred_local_o), 0);
    check("R5", "global guess", int'(pred_global_o), 1);
    check("R6", "chooser trained to global", int'(pred_taken_o), 1);
  endtask

  task automatic t_agree();
    do_reset();
    retire(10'h030, 12'h006, 1'b1, 1'b1, 1'b1);
    recover(11'h003, 1'b0);
    peek(10'h030);
    check("R7", "global guess", int'(pred_global_o), 1);
    check("R7", "chooser untouched picks local", int'(pred_taken_o), 0);
  endtask

  task automatic t_spec();
    do_reset();
    retire(10'h040, 12'h100, 1'b0, 1'b0, 1'b1);
    peek(10'h041);
    check("R8", "first taken", int'(pred_taken_o), 1);
    step(10'h041);
    peek(10'h041);
    check("R8", "ghist after one", int'(pred_ghist_o), 1);
    step(10'h041);
    peek(10'h040);
    check("R8", "ghist after two", int'(pred_ghist_o), 3);
    check("R8", "third not taken", int'(pred_taken_o), 0);
    step(10'h040);
    peek(10'h040);
    check("R8", "ghist after three", int'(pred_ghist_o), 6);
    peek(10'h041);
    repeat (3) @(negedge clk);
    check("R9", "ghist holds while idle", int'(pred_ghist_o), 6);
  endtask

  task automatic t_rec_prio();
    do_reset();
    pred_valid_i = 1'b1; pred_pc_i = 10'h000;
    recover(11'h400, 1'b0);
    pred_valid_i = 1'b0;
    peek(10'h000);
    check("R10", "recover beats predict", int'(pred_ghist_o), 'h800);
  endtask

  task automatic t_gsat();
    do_reset();
    for (int k = 0; k < 3; k++) retire(10'h050, 12'h000, 1'b0, 1'b0, 1'b1);
    retire(10'h050, 12'h000, 1'b0, 1'b0, 1'b0);
    peek(10'h051);
    check("R11", "2-bit top saturates", int'(pred_global_o), 1);
    for (int k = 0; k < 3; k++) retire(10'h051, 12'h007, 1'b0, 1'b0, 1'b0);
    retire(10'h051, 12'h007, 1'b0, 1'b0, 1'b1);
    recover(11'h003, 1'b1);
    peek(10'h052);
    check("R11", "2-bit bottom saturates", int'(pred_global_o), 0);
  endtask

  task automatic t_lsat();
    do_reset();
    for (int k = 0; k < 5; k++) retire(10'h060, 12'h010, 1'b0, 1'b0, 1'b0);
    retire(10'h060, 12'h010, 1'b0, 1'b0, 1'b1);
    peek(10'h061);
    check("R11", "3-bit bottom saturates", int'(pred_local_o), 0);
    do_reset();
    for (int k = 0; k < 16; k++) retire(10'h070, 12'h000, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 10; k++) retire(10'h071, 12'h000, 1'b0, 1'b0, 1'b1);
    peek(10'h070);
    check("R2", "full-taken history predicts taken", int'(pred_local_o), 1);
    retire(10'h071, 12'h000, 1'b0, 1'b0, 1'b0);
    peek(10'h070);
    check("R11", "3-bit top saturates", int'(pred_local_o), 1);
  endtask

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    t_reset();
    t_local();
    t_global();
    t_choose();
    t_agree();
    t_spec();
    t_rec_prio();
    t_gsat();
    t_lsat();
    summary();
    $finish;
  end
endmodule